// File: doc/BRIEF.md
# Multiplexed External Memory Controller

This block drives a narrow external memory port that is shared by a boot flash and a battery-backed SRAM. The port has one byte-wide bus that carries both address and data. Every byte transfer starts with three address phases: high, middle, then low. External latches capture these phases under two latch strobes. After that, the block runs a read or a write strobe cycle on the selected device. All timing is counted in core clock cycles and set by parameters, so each minimum timing interval can be met at the clock frequency in use.

On the core side, a single request carries a device select, a direction, an access size (byte, word or dword), a 20-bit address and write data. The block moves the bytes of the naturally aligned unit one by one, in ascending address order. It then reports completion together with the gathered read data.

When reset ends, the block reads the first sixteen bytes of flash before it accepts any request. It compares those bytes with a signature parameter. If any byte differs, a sticky status output reports that flash is missing. From then on, every flash request is refused with an error response and causes no activity on the port.

Top module: `xmem_ctrl`

## Requirements
- R1: While reset is held, `ready` and `boot_done` are low, both chip selects, `oe_n` and `bwe_n` are high, both latch strobes are low and `ad_oe` is low.
- R2: After reset the block performs sixteen single-byte flash reads at addresses 0x00000 up to 0x0000F in ascending order, then raises `boot_done`. `flash_absent` is set when any byte k differs from bits [8k+7:8k] of `BOOT_SIG`. `ready` stays low until `boot_done` is high.
- R3: Each byte transfer drives three address phases in this order: address bits [19:16] zero-extended to 8 bits with `ale_hi` alone pulsing, then bits [15:8] with `ale_lo` alone pulsing, then bits [7:0] with both strobes pulsing together. While any strobe is high, `ad_out` is stable and driven.
- R4: Each address phase holds its byte on the bus for at least `T_ASU` cycles before the strobes rise. The strobes stay high for exactly `T_ALE` cycles. The byte remains driven for at least one cycle after the strobes fall.
- R5: `ad_oe` is low in the cycle before `oe_n` falls and in every cycle in which `oe_n` is low.
- R6: On a write, the data byte is driven and stable for at least `T_DSU` cycles before `bwe_n` falls. `bwe_n` stays low for exactly `T_STB` cycles. The data is still driven in the cycle after `bwe_n` rises.
- R7: `req_size` selects the access size: 0 is one byte, 1 is two bytes, 2 is four bytes. The address is rounded down to a multiple of the size, and the bytes are transferred from that base in ascending order. Byte k of a read appears in `rsp_rdata[8k+7:8k]` and the unused upper bits are zero. Byte k of a write is taken from `req_wdata[8k+7:8k]`. The read data of a write response is zero.
- R8: `req_dev` 0 selects flash (`flash_ce_n` low during the transfer) and 1 selects SRAM (`sram_ce_n` low). The two chip selects are never low together.
- R9: While `flash_absent` is high, an accepted flash request gives `rsp_done` with `rsp_err` high in the next cycle, with no latch strobe and no chip select. SRAM requests still complete normally.
- R10: An accepted request with `req_size` equal to 3 gives `rsp_done` with `rsp_err` high in the next cycle, with no activity on the port.
- R11: A request is taken in a cycle where `ready` and `req_valid` are both high. `ready` is low from the cycle after a request is taken until the cycle in which its `rsp_done` appears, and `ready` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dev | input | 1 | 0 selects flash, 1 selects SRAM |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data, byte k in bits [8k+7:8k] |
| ready | output | 1 | Block is idle and can take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused, valid with rsp_done |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| boot_done | output | 1 | Signature check finished |
| flash_absent | output | 1 | Signature mismatch seen |
| ad_out | output | 8 | Shared bus, outgoing value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus, incoming value |
| ale_hi | output | 1 | First address latch strobe |
| ale_lo | output | 1 | Second address latch strobe |
| flash_ce_n | output | 1 | Flash chip select, active low |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| bwe_n | output | 1 | Byte write enable, active low |

## Verification
The assertions assume that the core side holds each request field steady only in the cycle where `req_valid` meets `ready`. They also assume that the external device drives `ad_in` only while `oe_n` is low. The bench meets both assumptions: it raises `req_valid` for exactly one cycle, and only after it has seen `ready`. Its memory model places data on `ad_in` only while `oe_n` is low, using the address that its own latch model captured from the strobes. The timing properties assume that every timing parameter is at least one cycle, and the bench uses small values above that limit.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;

  typedef enum logic [1:0] {
    T_BOOT = 2'd0,
    T_IDLE = 2'd1,
    T_XFER = 2'd2
  } top_st_e;

  typedef enum logic [3:0] {
    C_IDLE = 4'd0,
    C_ASET = 4'd1,
    C_APUL = 4'd2,
    C_AHLD = 4'd3,
    C_TURN = 4'd4,
    C_RSTB = 4'd5,
    C_DSET = 4'd6,
    C_WSTB = 4'd7,
    C_WHLD = 4'd8,
    C_ENDC = 4'd9
  } cyc_st_e;

  // number of bytes moved for a size code; zero marks an illegal code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // round an address down to the natural boundary of its size
  function automatic logic [31:0] align_addr(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd1:    return {a[31:1], 1'b0};
      2'd2:    return {a[31:2], 2'b00};
      default: return a;
    endcase
  endfunction

  // byte shown on the shared bus for address phase ph (0 high, 1 middle, 2 low)
  function automatic logic [7:0] addr_phase_byte(input logic [31:0] a, input logic [1:0] ph);
    case (ph)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

endpackage

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int T_ASU  = 2,
  parameter int T_ALE  = 2,
  parameter int T_AH   = 2,
  parameter int T_DSU  = 2,
  parameter int T_STB  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic              dev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              idle,
  output logic              byte_done,
  output logic [7:0]        rbyte,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic              ale_hi,
  output logic              ale_lo,
  output logic              flash_ce_n,
  output logic              sram_ce_n,
  output logic              oe_n,
  output logic              bwe_n
);

  localparam int TM_A = (T_ASU > T_ALE) ? T_ASU : T_ALE;
  localparam int TM_B = (T_AH > T_DSU) ? T_AH : T_DSU;
  localparam int TM_C = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TMAX = (TM_C > T_STB) ? TM_C : T_STB;
  localparam int CW   = $clog2(TMAX + 1);

  cyc_st_e           st, st_n;
  logic [1:0]        ph, ph_n;
  logic [CW-1:0]     tcnt;
  logic              l_wr, l_dev;
  logic [ADDR_W-1:0] l_addr;
  logic [7:0]        l_wbyte;

  // named internal events
  logic ev_tick, ev_sample, ev_addr_st, ev_data_st, ev_sel;

  function automatic logic [CW-1:0] stay_len(input cyc_st_e s);
    case (s)
      C_ASET:  return CW'(T_ASU - 1);
      C_APUL:  return CW'(T_ALE - 1);
      C_AHLD:  return CW'(T_AH - 1);
      C_DSET:  return CW'(T_DSU - 1);
      C_WSTB:  return CW'(T_STB - 1);
      C_RSTB:  return CW'(T_STB - 1);
      default: return '0;
    endcase
  endfunction

  assign ev_tick   = (tcnt == '0);
  assign ev_sample = (st == C_RSTB) && ev_tick;

  always_comb begin
    st_n = st;
    ph_n = ph;
    case (st)
      C_IDLE: if (start) begin st_n = C_ASET; ph_n = 2'd0; end
      C_ASET: if (ev_tick) st_n = C_APUL;
      C_APUL: if (ev_tick) st_n = C_AHLD;
      C_AHLD: if (ev_tick) begin
        if (ph == 2'd2) st_n = l_wr ? C_DSET : C_TURN;
        else begin st_n = C_ASET; ph_n = ph + 2'd1; end
      end
      C_TURN: if (ev_tick) st_n = C_RSTB;
      C_RSTB: if (ev_tick) st_n = C_ENDC;
      C_DSET: if (ev_tick) st_n = C_WSTB;
      C_WSTB: if (ev_tick) st_n = C_WHLD;
      C_WHLD: if (ev_tick) st_n = C_ENDC;
      C_ENDC: if (ev_tick) st_n = C_IDLE;
      default: st_n = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      ph      <= 2'd0;
      tcnt    <= '0;
      l_wr    <= 1'b0;
      l_dev   <= 1'b0;
      l_addr  <= '0;
      l_wbyte <= '0;
      rbyte   <= '0;
    end else begin
      st <= st_n;
      ph <= ph_n;
      if (st_n != st) tcnt <= stay_len(st_n);
      else if (tcnt != '0) tcnt <= tcnt - 1'b1;
      if (st == C_IDLE && start) begin
        l_wr    <= wr;
        l_dev   <= dev;
        l_addr  <= addr;
        l_wbyte <= wbyte;
      end
      if (ev_sample) rbyte <= ad_in;
    end
  end

  assign ev_addr_st = (st == C_ASET) || (st == C_APUL) || (st == C_AHLD);
  assign ev_data_st = (st == C_DSET) || (st == C_WSTB) || (st == C_WHLD);
  assign ev_sel     = (st == C_TURN) || (st == C_RSTB) || ev_data_st;

  assign idle       = (st == C_IDLE);
  assign byte_done  = (st == C_ENDC) && ev_tick;
  assign ad_oe      = ev_addr_st || ev_data_st;
  assign ad_out     = ev_addr_st ? addr_phase_byte(32'(l_addr), ph) :
                      ev_data_st ? l_wbyte : 8'h00;
  assign ale_hi     = (st == C_APUL) && (ph != 2'd1);
  assign ale_lo     = (st == C_APUL) && (ph != 2'd0);
  assign flash_ce_n = !(ev_sel && !l_dev);
  assign sram_ce_n  = !(ev_sel && l_dev);
  assign oe_n       = (st != C_RSTB);
  assign bwe_n      = (st != C_WSTB);

  // R3: latched byte held while strobes are high
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((ale_hi || ale_lo) && $past(ale_hi || ale_lo)) |-> (ad_oe && $stable(ad_out)));

  // R4: address still driven after the strobes fall
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_hi || ale_lo) |-> (ad_oe && $stable(ad_out)));

  // R5: no drive while the device may drive
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe);

  // R5: one released cycle before output enable
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(ad_oe));

  // R6: data set up before the write strobe
  a_r6_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bwe_n) |-> ($past(ad_oe) && $stable(ad_out)));

  // R6: data held after the write strobe
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bwe_n) |-> (ad_oe && $stable(ad_out)));

  // R8: never both devices selected
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_ce_n && !sram_ce_n));

endmodule

// File: rtl/xmem_sigchk.sv
`timescale 1ns/1ps
module xmem_sigchk #(
  parameter int                     SIG_BYTES = 16,
  parameter logic [8*SIG_BYTES-1:0] SIG       = '0,
  parameter int                     IW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [IW-1:0] chk_idx,
  input  logic [7:0]    chk_byte,
  output logic          miss_now
);

  logic       miss_q;
  logic [7:0] exp_byte;
  logic       ev_diff;

  assign exp_byte = 8'(SIG >> (32'(chk_idx) * 8));
  assign ev_diff  = chk_en && (chk_byte != exp_byte);
  assign miss_now = miss_q || ev_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= 1'b0;
    else if (ev_diff) miss_q <= 1'b1;
  end

  // R2: a seen mismatch is never forgotten before reset
  a_r2_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |=> miss_q);

endmodule

// File: rtl/xmem_ctrl.sv
`timescale 1ns/1ps
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int                     ADDR_W    = 20,
  parameter int                     DATA_W    = 32,
  parameter int                     SIG_BYTES = 16,
  parameter logic [8*SIG_BYTES-1:0] BOOT_SIG  = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
  parameter int                     T_ASU     = 2,
  parameter int                     T_ALE     = 2,
  parameter int                     T_AH      = 2,
  parameter int                     T_DSU     = 2,
  parameter int                     T_STB     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dev,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              boot_done,
  output logic              flash_absent,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic              ale_hi,
  output logic              ale_lo,
  output logic              flash_ce_n,
  output logic              sram_ce_n,
  output logic              oe_n,
  output logic              bwe_n
);

  localparam int DATA_BYTES = DATA_W / 8;
  localparam int NB         = (SIG_BYTES > DATA_BYTES) ? SIG_BYTES : DATA_BYTES;
  localparam int IW         = $clog2(NB);

  top_st_e           st;
  logic [IW-1:0]     idx, l_last;
  logic [ADDR_W-1:0] l_base;
  logic              l_wr, l_dev;
  logic [DATA_W-1:0] l_wdata, acc, acc_n;

  logic              cyc_start, cyc_idle, cyc_done;
  logic [7:0]        cyc_rbyte, cyc_wbyte;
  logic [ADDR_W-1:0] cyc_addr;
  logic              sig_miss;

  // named internal events
  logic ev_take, ev_reject, ev_boot_byte, ev_last;

  assign ready        = (st == T_IDLE);
  assign ev_take      = ready && req_valid;
  assign ev_reject    = (size_bytes(req_size) == 3'd0) || (!req_dev && flash_absent);
  assign ev_boot_byte = (st == T_BOOT) && cyc_done;
  assign ev_last      = (idx == l_last);

  assign cyc_start = (st != T_IDLE) && cyc_idle;
  assign cyc_addr  = (st == T_BOOT) ? ADDR_W'(idx) : (l_base + ADDR_W'(idx));
  assign cyc_wbyte = 8'(l_wdata >> {idx, 3'b000});

  always_comb begin
    acc_n = acc;
    acc_n[{idx, 3'b000} +: 8] = cyc_rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= T_BOOT;
      idx          <= '0;
      l_last       <= '0;
      l_base       <= '0;
      l_wr         <= 1'b0;
      l_dev        <= 1'b0;
      l_wdata      <= '0;
      acc          <= '0;
      rsp_done     <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      boot_done    <= 1'b0;
      flash_absent <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        T_BOOT: if (cyc_done) begin
          if (idx == IW'(SIG_BYTES - 1)) begin
            st           <= T_IDLE;
            boot_done    <= 1'b1;
            flash_absent <= sig_miss;
            idx          <= '0;
          end else idx <= idx + 1'b1;
        end
        T_IDLE: if (ev_take) begin
          if (ev_reject) begin
            rsp_done  <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            st      <= T_XFER;
            idx     <= '0;
            l_base  <= ADDR_W'(align_addr(32'(req_addr), req_size));
            l_last  <= IW'(size_bytes(req_size) - 3'd1);
            l_wr    <= req_write;
            l_dev   <= req_dev;
            l_wdata <= req_wdata;
            acc     <= '0;
          end
        end
        T_XFER: if (cyc_done) begin
          acc <= acc_n;
          if (ev_last) begin
            st        <= T_IDLE;
            rsp_done  <= 1'b1;
            rsp_rdata <= l_wr ? '0 : acc_n;
          end else idx <= idx + 1'b1;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  xmem_seq #(
    .ADDR_W(ADDR_W), .T_ASU(T_ASU), .T_ALE(T_ALE),
    .T_AH(T_AH), .T_DSU(T_DSU), .T_STB(T_STB)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cyc_start),
    .wr         ((st == T_XFER) && l_wr),
    .dev        ((st == T_XFER) && l_dev),
    .addr       (cyc_addr),
    .wbyte      (cyc_wbyte),
    .idle       (cyc_idle),
    .byte_done  (cyc_done),
    .rbyte      (cyc_rbyte),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ad_in      (ad_in),
    .ale_hi     (ale_hi),
    .ale_lo     (ale_lo),
    .flash_ce_n (flash_ce_n),
    .sram_ce_n  (sram_ce_n),
    .oe_n       (oe_n),
    .bwe_n      (bwe_n)
  );

  xmem_sigchk #(
    .SIG_BYTES(SIG_BYTES), .SIG(BOOT_SIG), .IW(IW)
  ) sig_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (ev_boot_byte),
    .chk_idx  (idx),
    .chk_byte (cyc_rbyte),
    .miss_now (sig_miss)
  );

  // R2: no request taken before the boot check ends
  a_r2_boot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !ready);

  // R9: refused flash request answers with an error next cycle
  a_r9_absent_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && !req_dev && flash_absent) |=> (rsp_done && rsp_err));

  // R9: flash never selected once it is marked missing
  a_r9_flash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flash_absent |-> flash_ce_n);

  // R10: illegal size refused next cycle
  a_r10_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && req_size == 2'd3) |=> (rsp_done && rsp_err));

  // R11: the response comes with the block idle again
  a_r11_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ready);

endmodule

// File: tb/xmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_ctrl_tb_top;

  localparam int T_ASU = 2;
  localparam int T_ALE = 2;
  localparam int T_AH  = 2;
  localparam int T_DSU = 2;
  localparam int T_STB = 3;
  localparam logic [127:0] SIG = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dev = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ready, rsp_done, rsp_err, boot_done, flash_absent;
  logic [31:0] rsp_rdata;
  logic [7:0]  ad_out, ad_in;
  logic        ad_oe, ale_hi, ale_lo, flash_ce_n, sram_ce_n, oe_n, bwe_n;

  always #10 clk = ~clk;

  xmem_ctrl #(
    .ADDR_W(20), .DATA_W(32), .SIG_BYTES(16), .BOOT_SIG(SIG),
    .T_ASU(T_ASU), .T_ALE(T_ALE), .T_AH(T_AH), .T_DSU(T_DSU), .T_STB(T_STB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dev(req_dev), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .boot_done(boot_done),
    .flash_absent(flash_absent), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale_hi(ale_hi), .ale_lo(ale_lo), .flash_ce_n(flash_ce_n),
    .sram_ce_n(sram_ce_n), .oe_n(oe_n), .bwe_n(bwe_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // ---------------- memory model ----------------
  bit         flash_good = 1'b1;
  logic [7:0] dev_sram [int];
  logic [7:0] exp_sram [int];

  function automatic logic [7:0] sram_init(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] flash_byte(input logic [19:0] a);
    logic [7:0] b;
    if (a < 20'd16) begin
      b = 8'(SIG >> (a * 8));
      if (!flash_good && a == 20'd7) b = b ^ 8'h01;
    end else b = 8'(a * 7 + 3);
    return b;
  endfunction

  function automatic logic [7:0] dev_sram_rd(input logic [19:0] a);
    if (dev_sram.exists(int'(a))) return dev_sram[int'(a)];
    return sram_init(a);
  endfunction

  function automatic logic [7:0] exp_sram_rd(input logic [19:0] a);
    if (exp_sram.exists(int'(a))) return exp_sram[int'(a)];
    return sram_init(a);
  endfunction

  // ---------------- bus monitor ----------------
  logic [7:0]  lat_h = 0, lat_m = 0, lat_l = 0;
  logic [7:0]  drv = 0;
  logic [25:0] blog [$];
  int          ale_events = 0;
  int          sc = 0, ale_w = 0, bwe_w = 0;
  logic        p_ale = 0, p_oe = 0, p_oen = 1, p_bwen = 1;
  logic [7:0]  p_ad = 0;

  assign ad_in = drv;

  always @(negedge clk) begin
    logic        ale;
    logic [23:0] la;
    if (rst_n) begin
      ale = ale_hi | ale_lo;
      if (ad_oe && p_oe && ad_out == p_ad) sc++;
      else sc = ad_oe ? 1 : 0;
      if (ale && !p_ale) begin
        ale_events++;
        chk(sc - 1 >= T_ASU, "R4 address setup cycles", sc - 1, T_ASU);
        ale_w = 1;
      end else if (ale) ale_w++;
      if (!ale && p_ale) begin
        chk(ale_w == T_ALE, "R4 strobe width", ale_w, T_ALE);
        chk(ad_oe && ad_out == p_ad, "R4 address hold", ad_out, p_ad);
      end
      if (ale_hi && !ale_lo) lat_h = ad_out;
      if (ale_lo && !ale_hi) lat_m = ad_out;
      if (ale_hi && ale_lo)  lat_l = ad_out;
      la = {lat_h, lat_m, lat_l};
      if (!oe_n && p_oen) begin
        chk(!ad_oe && !p_oe, "R5 bus released before oe_n", {ad_oe, p_oe}, 0);
        chk(flash_ce_n != sram_ce_n, "R8 exactly one select", {flash_ce_n, sram_ce_n}, 2'b01);
        blog.push_back({1'b0, !sram_ce_n, la});
      end
      if (!oe_n) drv = !sram_ce_n ? dev_sram_rd(la[19:0]) : flash_byte(la[19:0]);
      else drv = 8'h00;
      if (!bwe_n && p_bwen) begin
        chk(sc - 1 >= T_DSU, "R6 data setup cycles", sc - 1, T_DSU);
        chk(flash_ce_n != sram_ce_n, "R8 exactly one select", {flash_ce_n, sram_ce_n}, 2'b01);
        blog.push_back({1'b1, !sram_ce_n, la});
        bwe_w = 1;
      end else if (!bwe_n) bwe_w++;
      if (!bwe_n && !sram_ce_n) dev_sram[int'(la[19:0])] = ad_out;
      if (bwe_n && !p_bwen) begin
        chk(bwe_w == T_STB, "R6 write strobe width", bwe_w, T_STB);
        chk(ad_oe && ad_out == p_ad, "R6 data hold", ad_out, p_ad);
      end
      p_ale = ale; p_oe = ad_oe; p_ad = ad_out; p_oen = oe_n; p_bwen = bwe_n;
    end else begin
      p_ale = 0; p_oe = 0; p_oen = 1; p_bwen = 1; sc = 0; drv = 0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [32:0] exp_q [$];

  always @(negedge clk) begin
    logic [32:0] e;
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(rsp_err == e[32], "R9 R10 error flag", rsp_err, e[32]);
        chk(rsp_rdata == e[31:0], "R7 read data", rsp_rdata, e[31:0]);
        chk(ready, "R11 ready with response", ready, 1);
      end
    end
  end

  bit absent_exp = 1'b0;

  task automatic do_req(input bit dev, input bit wr, input logic [1:0] sz,
                        input logic [19:0] a, input logic [31:0] wd);
    int          n, ev0, guard;
    bit          err;
    logic [19:0] base;
    logic [31:0] rd;
    logic [25:0] ent;
    while (!ready) @(negedge clk);
    blog.delete();
    ev0 = ale_events;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    base = (n == 0) ? a : (a & ~20'(n - 1));
    err = (n == 0) || (!dev && absent_exp);
    rd = '0;
    if (!err && !wr)
      for (int k = 0; k < n; k++)
        rd[8*k +: 8] = dev ? exp_sram_rd(base + 20'(k)) : flash_byte(base + 20'(k));
    if (!err && wr && dev)
      for (int k = 0; k < n; k++) exp_sram[int'(base + 20'(k))] = wd[8*k +: 8];
    exp_q.push_back({err, rd});
    req_valid = 1'b1; req_dev = dev; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (!err) chk(!ready, "R11 ready low while busy", ready, 0);
    guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin @(negedge clk); guard++; end
    chk(exp_q.size() == 0, "R11 response arrived", exp_q.size(), 0);
    if (err) chk(ale_events == ev0, "R9 R10 no port activity", ale_events - ev0, 0);
    chk(blog.size() == (err ? 0 : n), "R7 byte transfer count", blog.size(), err ? 0 : n);
    for (int k = 0; k < blog.size() && k < n; k++) begin
      ent = {wr, dev, 4'h0, base + 20'(k)};
      chk(blog[k] == ent, "R3 R7 R8 transfer address and device", blog[k], ent);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ready && !boot_done, "R1 ready and boot_done low", {ready, boot_done}, 0);
    chk(flash_ce_n && sram_ce_n && oe_n && bwe_n, "R1 strobes inactive",
        {flash_ce_n, sram_ce_n, oe_n, bwe_n}, 4'hF);
    chk(!ale_hi && !ale_lo && !ad_oe, "R1 bus idle", {ale_hi, ale_lo, ad_oe}, 0);
    blog.delete();
    rst_n = 1'b1;
  endtask

  task automatic wait_boot(input bit exp_absent);
    int guard = 0;
    logic [25:0] ent;
    while (!boot_done && guard < 5000) begin
      chk(!ready, "R2 ready low during boot", ready, 0);
      @(negedge clk); guard++;
    end
    chk(boot_done, "R2 boot finished", boot_done, 1);
    chk(flash_absent == exp_absent, "R2 signature verdict", flash_absent, exp_absent);
    chk(blog.size() == 16, "R2 boot read count", blog.size(), 16);
    for (int k = 0; k < blog.size() && k < 16; k++) begin
      ent = {2'b00, 24'(k)};
      chk(blog[k] == ent, "R2 boot address order", blog[k], ent);
    end
  endtask

  initial begin
    flash_good = 1'b1;
    absent_exp = 1'b0;
    do_reset();
    wait_boot(1'b0);
    // reads of each size, aligned down
    do_req(1'b1, 1'b0, 2'd0, 20'h12345, 32'h0);
    do_req(1'b1, 1'b0, 2'd1, 20'h00103, 32'h0);
    do_req(1'b1, 1'b0, 2'd2, 20'hABCDE, 32'h0);
    do_req(1'b0, 1'b0, 2'd2, 20'h00021, 32'h0);
    do_req(1'b0, 1'b0, 2'd0, 20'h00007, 32'h0);
    // writes, then read back
    do_req(1'b1, 1'b1, 2'd2, 20'h40000, 32'h11223344);
    do_req(1'b1, 1'b0, 2'd2, 20'h40000, 32'h0);
    do_req(1'b1, 1'b1, 2'd1, 20'h40005, 32'hFFFFBEEF);
    do_req(1'b1, 1'b0, 2'd2, 20'h40006, 32'h0);
    do_req(1'b1, 1'b1, 2'd0, 20'hFFFFF, 32'hAAAAAA5A);
    do_req(1'b1, 1'b0, 2'd0, 20'hFFFFF, 32'h0);
    chk(dev_sram_rd(20'h40004) == 8'hEF && dev_sram_rd(20'h40005) == 8'hBE,
        "R7 word write lanes", {dev_sram_rd(20'h40005), dev_sram_rd(20'h40004)}, 16'hBEEF);
    // illegal size
    do_req(1'b1, 1'b0, 2'd3, 20'h00010, 32'h0);
    do_req(1'b0, 1'b1, 2'd3, 20'h00010, 32'h0);
    // boot with a corrupted signature
    flash_good = 1'b0;
    absent_exp = 1'b1;
    do_reset();
    wait_boot(1'b1);
    do_req(1'b0, 1'b0, 2'd2, 20'h00100, 32'h0);
    do_req(1'b0, 1'b1, 2'd0, 20'h00100, 32'h5);
    do_req(1'b1, 1'b0, 2'd1, 20'h40004, 32'h0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule